// File: doc/BRIEF.md
# Dispatch Slot Allocation Controller

This block does the per-cycle bandwidth bookkeeping for the dispatch point of an out-of-order front end. Each clock it looks at one candidate instruction (its micro-op count plus two packing flags) and the readiness of the reorder buffer, the register file and the following stage. From these it decides whether the candidate leaves in that clock. It keeps a count of the slots still free in the current dispatch cycle. A dispatch cycle may span several clocks, and a `tick_i` pulse marks the clock that opens a new one.

An instruction carrying more micro-ops than the dispatch width is still accepted. Its first `W` micro-ops fill the cycle, and the excess goes into a carry-over counter that drains at each later cycle boundary. A begin-group instruction needs a fresh, untouched cycle. An end-group instruction closes the cycle behind it. Stall causes and a per-clock dispatched micro-op count are reported combinationally. The block stores no instructions: acceptance means the instruction moves on in the same clock.

Top module: `dsp_slot_ctrl`

## Requirements
- R1: After synchronous reset, `slots_o` equals the dispatch width W and `carry_o` is zero.
- R2: In a clock with `tick_i` high and no carry pending, the free-slot count is reloaded to W before the candidate is judged.
- R3: A candidate is accepted only if the free count is nonzero and at least min(uops, W). An accepted candidate with uops ≤ W lowers the free count by uops.
- R4: A candidate with uops > W is accepted only when all W slots are free. Acceptance leaves zero free slots and loads the carry counter with uops − W.
- R5: In a clock with `tick_i` high and carry C pending, min(C, W) slots go to the carried instruction. The carry drops by that amount, and W − min(C, W) slots are free for the candidate in the same clock.
- R6: After an accepted candidate with `req_end_i` set, `slots_o` is zero.
- R7: A candidate with `req_begin_i` set is accepted only when the free count (after any tick processing) equals W.
- R8: Acceptance also requires `rob_ready_i`, `rf_ready_i` and `nxt_ready_i`. When the slot rules pass, a low `rob_ready_i` raises `stall_rob_o` and a low `rf_ready_i` raises `stall_rf_o`. A low `nxt_ready_i` blocks acceptance without raising either stall.
- R9: `disp_uops_o` equals the carried micro-ops consumed in that clock plus min(uops, W) when the candidate is accepted.
- R10: A valid candidate presented while carry is still nonzero after tick processing is refused and raises `busy_err_o`.
- R11: A `DISP_W` of zero makes the dispatch width equal to `ISSUE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | This clock opens a new dispatch cycle |
| req_valid_i | input | 1 | Candidate instruction present |
| req_uops_i | input | UOP_W | Candidate micro-op count |
| req_begin_i | input | 1 | Candidate must start a dispatch cycle |
| req_end_i | input | 1 | Candidate closes the dispatch cycle |
| rob_ready_i | input | 1 | Reorder buffer has room for the micro-ops |
| rf_ready_i | input | 1 | Register file can take the destinations |
| nxt_ready_i | input | 1 | Following stage accepts this clock |
| accept_o | output | 1 | Candidate dispatched this clock |
| stall_rob_o | output | 1 | Refused for lack of reorder buffer space |
| stall_rf_o | output | 1 | Refused for lack of register file space |
| busy_err_o | output | 1 | Candidate presented while carry-over pending |
| disp_uops_o | output | clog2(W+1) | Micro-ops dispatched this clock |
| slots_o | output | clog2(W+1) | Free slots left in the current dispatch cycle |
| carry_o | output | UOP_W | Pending carry-over micro-ops |

## Verification
The bench builds the block with `DISP_W` = 0, `ISSUE_W` = 4 and `UOP_W` = 4. The zero width therefore exercises the fallback to the issue width. A 4-bit count allows instructions of up to 15 micro-ops, which is almost four times the width. That range covers carry-over draining across three further cycle boundaries, a partial last drain that leaves free slots for a new candidate, and refused requests during carry. The small width also makes partial-cycle packing, begin-group refusal and end-group closure quick to reach.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    // Effective dispatch width: zero selects the machine issue width.
    function automatic int eff_width(input int disp_w, input int issue_w);
        return (disp_w == 0) ? issue_w : disp_w;
    endfunction

    // Bits needed to hold a slot count from 0 up to the width.
    function automatic int slot_bits(input int disp_w, input int issue_w);
        return $clog2(eff_width(disp_w, issue_w) + 1);
    endfunction

    typedef struct packed {
        logic valid;
        logic begin_grp;
        logic end_grp;
    } cand_t;

    typedef struct packed {
        logic rob;
        logic rf;
        logic nxt;
    } rdy_t;

    typedef enum logic [1:0] {
        VERD_IDLE = 2'd0,
        VERD_TAKE = 2'd1,
        VERD_HOLD = 2'd2,
        VERD_BUSY = 2'd3
    } verdict_t;

endpackage

// File: rtl/dsp_refill.sv
// Cycle-boundary processing: reload or drain carry-over before judging.
module dsp_refill #(
    parameter int W      = 4,
    parameter int SLOT_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              tick,
    input  logic [SLOT_W-1:0] slots_q,
    input  logic [CNT_W-1:0]  carry_q,
    output logic [SLOT_W-1:0] slots_eff,
    output logic [CNT_W-1:0]  carry_eff,
    output logic [SLOT_W-1:0] consumed
);
    localparam logic [SLOT_W-1:0] FULL   = SLOT_W'(W);
    localparam logic [CNT_W-1:0]  W_CNT  = CNT_W'(W);

    always_comb begin
        consumed  = '0;
        slots_eff = slots_q;
        carry_eff = carry_q;
        if (tick) begin
            if (carry_q == '0) begin
                slots_eff = FULL;
            end else begin
                consumed  = (carry_q >= W_CNT) ? FULL : SLOT_W'(carry_q);
                slots_eff = FULL - consumed;
                carry_eff = carry_q - CNT_W'(consumed);
            end
        end
    end
endmodule

// File: rtl/dsp_admit.sv
// Admission decision: slot rules, grouping rules, readiness and stall causes.
module dsp_admit
    import dsp_pkg::*;
#(
    parameter int W      = 4,
    parameter int SLOT_W = 3,
    parameter int UOP_W  = 4
) (
    input  cand_t             cand,
    input  rdy_t              rdy,
    input  logic [UOP_W-1:0]  uops,
    input  logic [SLOT_W-1:0] slots_eff,
    input  logic [UOP_W-1:0]  carry_eff,
    output verdict_t          verdict,
    output logic [SLOT_W-1:0] need,
    output logic              wide,
    output logic              stall_rob,
    output logic              stall_rf
);
    localparam logic [SLOT_W-1:0] FULL = SLOT_W'(W);
    localparam logic [UOP_W-1:0]  W_U  = UOP_W'(W);

    logic slot_ok;
    logic all_rdy;

    always_comb begin
        wide    = (uops > W_U);
        need    = wide ? FULL : SLOT_W'(uops);
        slot_ok = (slots_eff != '0) && (need <= slots_eff)
                  && (!cand.begin_grp || slots_eff == FULL)
                  && (!wide || slots_eff == FULL)
                  && (carry_eff == '0);
        all_rdy = rdy.rob && rdy.rf && rdy.nxt;

        stall_rob = cand.valid && slot_ok && !rdy.rob;
        stall_rf  = cand.valid && slot_ok && !rdy.rf;

        if (!cand.valid)
            verdict = VERD_IDLE;
        else if (carry_eff != '0)
            verdict = VERD_BUSY;
        else if (slot_ok && all_rdy)
            verdict = VERD_TAKE;
        else
            verdict = VERD_HOLD;
    end
endmodule

// File: rtl/dsp_track.sv
// State registers: free slots of the current cycle and carry-over count.
module dsp_track
    import dsp_pkg::*;
#(
    parameter int W      = 4,
    parameter int SLOT_W = 3,
    parameter int UOP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          verdict,
    input  logic              wide,
    input  logic              end_grp,
    input  logic [UOP_W-1:0]  uops,
    input  logic [SLOT_W-1:0] slots_eff,
    input  logic [UOP_W-1:0]  carry_eff,
    output logic [SLOT_W-1:0] slots_q,
    output logic [UOP_W-1:0]  carry_q
);
    localparam logic [SLOT_W-1:0] FULL = SLOT_W'(W);
    localparam logic [UOP_W-1:0]  W_U  = UOP_W'(W);

    logic [SLOT_W-1:0] slots_d;
    logic [UOP_W-1:0]  carry_d;

    always_comb begin
        slots_d = slots_eff;
        carry_d = carry_eff;
        if (verdict == VERD_TAKE) begin
            if (wide) begin
                slots_d = '0;
                carry_d = uops - W_U;
            end else begin
                slots_d = slots_eff - SLOT_W'(uops);
            end
            if (end_grp)
                slots_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= FULL;
            carry_q <= '0;
        end else begin
            slots_q <= slots_d;
            carry_q <= carry_d;
        end
    end
endmodule

// File: rtl/dsp_slot_ctrl.sv
module dsp_slot_ctrl
    import dsp_pkg::*;
#(
    parameter int DISP_W  = 0,
    parameter int ISSUE_W = 4,
    parameter int UOP_W   = 4
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      tick_i,
    input  logic                                      req_valid_i,
    input  logic [UOP_W-1:0]                          req_uops_i,
    input  logic                                      req_begin_i,
    input  logic                                      req_end_i,
    input  logic                                      rob_ready_i,
    input  logic                                      rf_ready_i,
    input  logic                                      nxt_ready_i,
    output logic                                      accept_o,
    output logic                                      stall_rob_o,
    output logic                                      stall_rf_o,
    output logic                                      busy_err_o,
    output logic [slot_bits(DISP_W, ISSUE_W)-1:0]     disp_uops_o,
    output logic [slot_bits(DISP_W, ISSUE_W)-1:0]     slots_o,
    output logic [UOP_W-1:0]                          carry_o
);
    localparam int EFF_W  = eff_width(DISP_W, ISSUE_W);
    localparam int SLOT_W = slot_bits(DISP_W, ISSUE_W);

    cand_t             cand;
    rdy_t              rdy;
    verdict_t          verdict;
    logic [SLOT_W-1:0] slots_q, slots_eff, consumed, need;
    logic [UOP_W-1:0]  carry_q, carry_eff;
    logic              wide;

    assign cand = '{valid: req_valid_i, begin_grp: req_begin_i, end_grp: req_end_i};
    assign rdy  = '{rob: rob_ready_i, rf: rf_ready_i, nxt: nxt_ready_i};

    dsp_refill #(.W(EFF_W), .SLOT_W(SLOT_W), .CNT_W(UOP_W)) u_refill (
        .tick      (tick_i),
        .slots_q   (slots_q),
        .carry_q   (carry_q),
        .slots_eff (slots_eff),
        .carry_eff (carry_eff),
        .consumed  (consumed)
    );

    dsp_admit #(.W(EFF_W), .SLOT_W(SLOT_W), .UOP_W(UOP_W)) u_admit (
        .cand      (cand),
        .rdy       (rdy),
        .uops      (req_uops_i),
        .slots_eff (slots_eff),
        .carry_eff (carry_eff),
        .verdict   (verdict),
        .need      (need),
        .wide      (wide),
        .stall_rob (stall_rob_o),
        .stall_rf  (stall_rf_o)
    );

    dsp_track #(.W(EFF_W), .SLOT_W(SLOT_W), .UOP_W(UOP_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .wide      (wide),
        .end_grp   (req_end_i),
        .uops      (req_uops_i),
        .slots_eff (slots_eff),
        .carry_eff (carry_eff),
        .slots_q   (slots_q),
        .carry_q   (carry_q)
    );

    assign accept_o    = (verdict == VERD_TAKE);
    assign busy_err_o  = (verdict == VERD_BUSY);
    assign disp_uops_o = consumed + (accept_o ? need : '0);
    assign slots_o     = slots_q;
    assign carry_o     = carry_q;
endmodule

// File: rtl/dsp_slot_chk.sv
module dsp_slot_chk #(
    parameter int W      = 4,
    parameter int SLOT_W = 3,
    parameter int UOP_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic [UOP_W-1:0]  req_uops_i,
    input logic              req_begin_i,
    input logic              req_end_i,
    input logic              rob_ready_i,
    input logic              rf_ready_i,
    input logic              nxt_ready_i,
    input logic              accept_o,
    input logic              busy_err_o,
    input logic [SLOT_W-1:0] disp_uops_o,
    input logic [SLOT_W-1:0] slots_o,
    input logic [UOP_W-1:0]  carry_o,
    input logic [SLOT_W-1:0] slots_eff,
    input logic [UOP_W-1:0]  carry_eff
);
    localparam logic [SLOT_W-1:0] FULL = SLOT_W'(W);
    localparam logic [UOP_W-1:0]  W_U  = UOP_W'(W);

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (slots_o == FULL && carry_o == '0)); // R1

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick_i && carry_o == '0) |-> slots_eff == FULL); // R2

    AST_NO_OVERDRAW: assert property (@(posedge clk) disable iff (rst)
        (accept_o && req_uops_i <= W_U) |-> SLOT_W'(req_uops_i) <= slots_eff); // R3

    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (accept_o && req_uops_i > W_U) |=> (slots_o == '0 && carry_o == $past(req_uops_i) - W_U)); // R4

    AST_END_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (accept_o && req_end_i) |=> slots_o == '0); // R6

    AST_BEGIN_FULL: assert property (@(posedge clk) disable iff (rst)
        (accept_o && req_begin_i) |-> slots_eff == FULL); // R7

    AST_READY_ALL: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (rob_ready_i && rf_ready_i && nxt_ready_i)); // R8

    AST_DISP_CAP: assert property (@(posedge clk) disable iff (rst)
        disp_uops_o <= FULL); // R9

    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (carry_eff != '0) |-> !accept_o); // R10

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_err_o && accept_o)); // R10
endmodule

bind dsp_slot_ctrl dsp_slot_chk #(.W(EFF_W), .SLOT_W(SLOT_W), .UOP_W(UOP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .req_uops_i  (req_uops_i),
    .req_begin_i (req_begin_i),
    .req_end_i   (req_end_i),
    .rob_ready_i (rob_ready_i),
    .rf_ready_i  (rf_ready_i),
    .nxt_ready_i (nxt_ready_i),
    .accept_o    (accept_o),
    .busy_err_o  (busy_err_o),
    .disp_uops_o (disp_uops_o),
    .slots_o     (slots_o),
    .carry_o     (carry_o),
    .slots_eff   (slots_eff),
    .carry_eff   (carry_eff)
);

// File: tb/sim_dsp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_dsp_slot_ctrl;
    localparam int W      = 4;
    localparam int UOP_W  = 4;
    localparam int SLOT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick, valid, bgn, endg, rob, rf, nxt;
    logic [UOP_W-1:0] uops;
    logic acc, srob, srf, berr;
    logic [SLOT_W-1:0] dcnt, slots;
    logic [UOP_W-1:0] carry;

    always #2.5 clk = ~clk;

    dsp_slot_ctrl #(.DISP_W(0), .ISSUE_W(W), .UOP_W(UOP_W)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .req_valid_i(valid),
        .req_uops_i(uops), .req_begin_i(bgn), .req_end_i(endg),
        .rob_ready_i(rob), .rf_ready_i(rf), .nxt_ready_i(nxt),
        .accept_o(acc), .stall_rob_o(srob), .stall_rf_o(srf),
        .busy_err_o(berr), .disp_uops_o(dcnt), .slots_o(slots), .carry_o(carry)
    );

    typedef struct {
        string tag;
        bit    acc, srob, srf, err;
        int    dcnt, slots, carry;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   m_slots = W;
    int   m_carry = 0;
    bit   done = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one clock of stimulus and queues the model's prediction.
    task automatic step(input bit t, input bit v, input int u, input bit b, input bit e,
                        input bit r_rob, input bit r_rf, input bit r_nxt, input string tag);
        exp_t x;
        int   av, cons, need;
        bit   ok;
        @(negedge clk);
        tick = t; valid = v; uops = UOP_W'(u); bgn = b; endg = e;
        rob = r_rob; rf = r_rf; nxt = r_nxt;
        cons = 0;
        av = m_slots;
        if (t) begin
            if (m_carry == 0) av = W;
            else begin
                cons = (m_carry < W) ? m_carry : W;
                av = W - cons;
                m_carry -= cons;
            end
        end
        need = (u < W) ? u : W;
        ok = (av != 0) && (need <= av) && (!b || av == W) && (m_carry == 0);
        x.tag  = tag;
        x.err  = v && (m_carry != 0);
        x.srob = v && ok && !r_rob;
        x.srf  = v && ok && !r_rf;
        x.acc  = v && ok && r_rob && r_rf && r_nxt;
        x.dcnt = cons + (x.acc ? need : 0);
        if (x.acc) begin
            if (u > W) begin av = 0; m_carry = u - W; end
            else av = av - u;
            if (e) av = 0;
        end
        m_slots = av;
        x.slots = m_slots;
        x.carry = m_carry;
        q.push_back(x);
    endtask

    // Monitor: combinational results before the edge, state after it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                chk(x.tag, "accept", int'(acc), int'(x.acc));
                chk(x.tag, "stall_rob", int'(srob), int'(x.srob));
                chk(x.tag, "stall_rf", int'(srf), int'(x.srf));
                chk(x.tag, "busy_err", int'(berr), int'(x.err));
                chk(x.tag, "disp_uops", int'(dcnt), x.dcnt);
                @(posedge clk);
                #1;
                chk(x.tag, "slots", int'(slots), x.slots);
                chk(x.tag, "carry", int'(carry), x.carry);
            end
        end
    end

    initial begin
        tick = 0; valid = 0; uops = '0; bgn = 0; endg = 0;
        rob = 1; rf = 1; nxt = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "reset slots", int'(slots), W);
        chk("R1", "reset carry", int'(carry), 0);
        // tag, then R2/R3: reload and narrow packing
        step(1, 1, 1, 0, 0, 1, 1, 1, "R2_reload");
        step(0, 1, 2, 0, 0, 1, 1, 1, "R3_pack");
        step(0, 1, 2, 0, 0, 1, 1, 1, "R3_short");
        step(0, 1, 1, 1, 0, 1, 1, 1, "R7_partial");
        step(1, 1, 1, 1, 0, 1, 1, 1, "R7_fresh");
        step(0, 1, 1, 0, 1, 1, 1, 1, "R6_close");
        step(0, 1, 1, 0, 0, 1, 1, 1, "R3_zero");
        // wide instruction and carry drain
        step(1, 1, 10, 0, 0, 1, 1, 1, "R4_wide");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R5_drain");
        step(1, 1, 1, 0, 0, 1, 1, 1, "R9_mix");
        step(1, 1, 15, 0, 0, 1, 1, 1, "R11_wide15");
        step(1, 1, 1, 0, 0, 1, 1, 1, "R10_busy");
        step(0, 1, 1, 0, 0, 1, 1, 1, "R10_hold");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R5_drain2");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R5_tail");
        // readiness and stall causes
        step(1, 1, 2, 0, 0, 0, 1, 1, "R8_rob");
        step(1, 1, 2, 0, 0, 1, 0, 1, "R8_rf");
        step(1, 1, 2, 0, 0, 1, 1, 0, "R8_nxt");
        step(1, 1, 2, 0, 0, 0, 0, 1, "R8_both");
        // wide candidate needs a full cycle
        step(1, 1, 1, 0, 0, 1, 1, 1, "R4_pre");
        step(0, 1, 5, 0, 0, 1, 1, 1, "R4_notfull");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R2_idle");
        step(0, 1, 4, 0, 0, 1, 1, 1, "R11_fullw");
        repeat (4) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule